// File: doc/BRIEF.md
# Vector Memory Address Generator

This block turns one vector load or store command into the ordered list of byte addresses for its elements, one address per cycle. A command gives a base address, a scalar stride, an element width code, an addressing mode and the active vector length. The block offers three address patterns:

- **Packed:** consecutive elements sit one element size apart.
- **Strided:** consecutive elements sit a fixed, signed byte distance apart.
- **Gather/scatter:** each element address is the base plus a per-element byte offset. The offset is read from an index vector, one element per cycle.

Addresses leave through a valid/ready handshake. A one-cycle completion pulse follows the last accepted address. The memory system, the data path and any translation or fault checking sit outside this block.

The index vector is read through a select output (`idx_sel_o`) and a data input (`idx_data_i`). The select is the number of the element being produced, and the offset is expected back in the same cycle. The vector length is taken from a run-time register value. It may be anything from zero up to the maximum vector length, which is 64 elements by default.

Top module: `vag_top`

## Requirements
- R1: With mode code 0 or 3 (packed), element i is at base + i × S, where S is 1, 2, 4 or 8 bytes for width codes 0, 1, 2 and 3. Addresses wrap modulo 2^AW.
- R2: With mode code 1 (strided), element i is at base + i × stride. The stride is a two's complement byte distance, and the result wraps modulo 2^AW.
- R3: With mode code 2 (gather/scatter), element i is at base + idx_data_i. The offset is zero-extended and the sum wraps modulo 2^AW. While element i is offered, idx_sel_o equals i.
- R4: A command of length L offers exactly L addresses, in element order 0 to L-1. Each address is consumed by a cycle where addr_valid_o and addr_ready_i are both high.
- R5: A requested length above MAX_VL is treated as MAX_VL.
- R6: A length of zero offers no address, and done_o is high in the cycle after the start cycle.
- R7: done_o is high for exactly one cycle, in the cycle after the last handshake, and addr_valid_o is low while done_o is high.
- R8: While addr_valid_o is high and addr_ready_i is low, addr_valid_o stays high and addr_o keeps its value in the next cycle.
- R9: busy_o is high from the cycle after an accepted start through the cycle where done_o is high. start_i is ignored while busy_o is high, and the running sequence continues unchanged.
- R10: After reset, addr_valid_o, done_o and busy_o are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Command request, taken when idle |
| mode_i | input | 2 | Addressing mode: 0 packed, 1 strided, 2 gather/scatter, 3 packed |
| ew_i | input | 2 | Element width code: 0 = 8 bit, 1 = 16 bit, 2 = 32 bit, 3 = 64 bit |
| base_i | input | AW | Base byte address |
| stride_i | input | AW | Signed byte stride for strided mode |
| vlen_i | input | VLW | Requested vector length |
| idx_sel_o | output | CW | Element number whose index offset is wanted |
| idx_data_i | input | IDXW | Unsigned byte offset for the selected element |
| addr_valid_o | output | 1 | An element address is offered |
| addr_ready_i | input | 1 | Consumer takes the offered address |
| addr_o | output | AW | Element byte address |
| done_o | output | 1 | One-cycle pulse after the sequence ends |
| busy_o | output | 1 | A sequence is in progress |

## Verification
In gather/scatter mode the held-address property relies on idx_data_i being a pure function of idx_sel_o. The offset source must not change an entry while a command is running. The bench meets this by driving idx_data_i combinationally from a fixed offset table that is indexed by idx_sel_o and never rewritten. Commands, and the stray starts used to probe the ignore rule, are driven only between clock edges. Stall patterns on addr_ready_i vary freely, which the handshake permits.

// File: rtl/vag_pkg.sv
package vag_pkg;

   typedef enum logic [1:0] {
      AM_PACKED  = 2'd0,
      AM_STRIDED = 2'd1,
      AM_INDEXED = 2'd2,
      AM_PACKED2 = 2'd3
   } amode_e;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_RUN  = 2'd1,
      ST_DONE = 2'd2
   } seq_st_e;

   // element size in bytes for a width code, as a 4-bit value (1,2,4,8)
   function automatic logic [3:0] elem_bytes(input logic [1:0] ew);
      return 4'd1 << ew;
   endfunction

endpackage

// File: rtl/vag_seq.sv
module vag_seq
   import vag_pkg::*;
#(
   parameter int MAX_VL = 64,
   parameter int VLW    = $clog2(MAX_VL + 1),
   parameter int CW     = $clog2(MAX_VL)
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           start_i,
   input  logic [VLW-1:0] vlen_i,
   input  logic           fire_i,
   output logic           load_o,
   output logic           valid_o,
   output logic           done_o,
   output logic           busy_o,
   output logic [CW-1:0]  cnt_o
);

   localparam logic [VLW-1:0] LIM = VLW'(MAX_VL);

   seq_st_e        st_q;
   logic [VLW-1:0] len_q;
   logic [VLW-1:0] cnt_q;
   logic [VLW-1:0] len_clamped;

   assign len_clamped = (vlen_i > LIM) ? LIM : vlen_i;
   assign load_o      = (st_q == ST_IDLE) && start_i;
   assign valid_o     = (st_q == ST_RUN);
   assign done_o      = (st_q == ST_DONE);
   assign busy_o      = (st_q != ST_IDLE);
   assign cnt_o       = cnt_q[CW-1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q  <= ST_IDLE;
         len_q <= '0;
         cnt_q <= '0;
      end else begin
         unique case (st_q)
            ST_IDLE: begin
               if (start_i) begin
                  len_q <= len_clamped;
                  cnt_q <= '0;
                  st_q  <= (len_clamped == '0) ? ST_DONE : ST_RUN;
               end
            end
            ST_RUN: begin
               if (fire_i) begin
                  cnt_q <= cnt_q + 1'b1;
                  if (cnt_q == len_q - 1'b1) st_q <= ST_DONE;
               end
            end
            default: st_q <= ST_IDLE;
         endcase
      end
   end

   AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_RUN) |-> (cnt_q < len_q) && (len_q <= LIM)); // R4

   AST_ZERO_LEN: assert property (@(posedge clk) disable iff (!rst_n)
      (load_o && vlen_i == '0) |=> done_o && !valid_o); // R6

   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o); // R7

   AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && start_i && !done_o) |=> $stable(len_q)); // R9

endmodule

// File: rtl/vag_agen.sv
module vag_agen
   import vag_pkg::*;
#(
   parameter int AW        = 32,
   parameter int IDXW      = 16,
   parameter bit HAS_INDEX = 1'b1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            load_i,
   input  logic            step_i,
   input  logic [1:0]      mode_i,
   input  logic [1:0]      ew_i,
   input  logic [AW-1:0]   base_i,
   input  logic [AW-1:0]   stride_i,
   input  logic [IDXW-1:0] idx_i,
   output logic [AW-1:0]   addr_o
);

   localparam int PADW = AW - 4;

   generate
      if (AW < 8) begin : g_bad_aw
         $error("vag_agen: AW must be at least 8");
      end
      if (IDXW > AW) begin : g_bad_idxw
         $error("vag_agen: IDXW must not exceed AW");
      end
   endgenerate

   amode_e        mode_q;
   logic [AW-1:0] base_q;
   logic [AW-1:0] acc_q;
   logic [AW-1:0] inc_q;
   logic [AW-1:0] inc_d;

   always_comb begin
      if (amode_e'(mode_i) == AM_STRIDED) inc_d = stride_i;
      else                                inc_d = {{PADW{1'b0}}, elem_bytes(ew_i)};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q <= AM_PACKED;
         base_q <= '0;
         acc_q  <= '0;
         inc_q  <= '0;
      end else if (load_i) begin
         mode_q <= amode_e'(mode_i);
         base_q <= base_i;
         acc_q  <= base_i;
         inc_q  <= inc_d;
      end else if (step_i) begin
         acc_q  <= acc_q + inc_q;
      end
   end

   generate
      if (HAS_INDEX) begin : g_index
         logic [AW-1:0] gather_addr;
         assign gather_addr = base_q + {{(AW-IDXW){1'b0}}, idx_i};
         assign addr_o = (mode_q == AM_INDEXED) ? gather_addr : acc_q;
      end else begin : g_no_index
         assign addr_o = acc_q;
      end
   endgenerate

   AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (step_i && mode_q != AM_INDEXED) |=> addr_o == $past(addr_o) + inc_q); // R2

   AST_LOAD_BASE: assert property (@(posedge clk) disable iff (!rst_n)
      (load_i && amode_e'(mode_i) != AM_INDEXED) |=> addr_o == $past(base_i)); // R1

endmodule

// File: rtl/vag_top.sv
module vag_top
   import vag_pkg::*;
#(
   parameter int AW        = 32,
   parameter int IDXW      = 16,
   parameter int MAX_VL    = 64,
   parameter bit HAS_INDEX = 1'b1,
   localparam int VLW      = $clog2(MAX_VL + 1),
   localparam int CW       = $clog2(MAX_VL)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            start_i,
   input  logic [1:0]      mode_i,
   input  logic [1:0]      ew_i,
   input  logic [AW-1:0]   base_i,
   input  logic [AW-1:0]   stride_i,
   input  logic [VLW-1:0]  vlen_i,
   output logic [CW-1:0]   idx_sel_o,
   input  logic [IDXW-1:0] idx_data_i,
   output logic            addr_valid_o,
   input  logic            addr_ready_i,
   output logic [AW-1:0]   addr_o,
   output logic            done_o,
   output logic            busy_o
);

   generate
      if (MAX_VL < 2) begin : g_bad_vl
         $error("vag_top: MAX_VL must be at least 2");
      end
   endgenerate

   logic load;
   logic fire;

   assign fire = addr_valid_o && addr_ready_i;

   vag_seq #(.MAX_VL(MAX_VL), .VLW(VLW), .CW(CW)) u_seq (
      .clk     (clk),
      .rst_n   (rst_n),
      .start_i (start_i),
      .vlen_i  (vlen_i),
      .fire_i  (fire),
      .load_o  (load),
      .valid_o (addr_valid_o),
      .done_o  (done_o),
      .busy_o  (busy_o),
      .cnt_o   (idx_sel_o)
   );

   vag_agen #(.AW(AW), .IDXW(IDXW), .HAS_INDEX(HAS_INDEX)) u_agen (
      .clk      (clk),
      .rst_n    (rst_n),
      .load_i   (load),
      .step_i   (fire),
      .mode_i   (mode_i),
      .ew_i     (ew_i),
      .base_i   (base_i),
      .stride_i (stride_i),
      .idx_i    (idx_data_i),
      .addr_o   (addr_o)
   );

   AST_HOLD_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
      (addr_valid_o && !addr_ready_i) |=> addr_valid_o && $stable(addr_o)); // R8

   AST_HOLD_SEL: assert property (@(posedge clk) disable iff (!rst_n)
      (addr_valid_o && !addr_ready_i) |=> $stable(idx_sel_o)); // R3

   AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> !addr_valid_o && busy_o); // R7

   AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done_o) |-> !$past(start_i) || $past(busy_o) || $past(vlen_i) == '0 ||
                        $past(fire)); // R4

endmodule

// File: tb/vag_top_tb.sv
module vag_top_tb;

   localparam int AW = 32;
   localparam int IDXW = 16;
   localparam int MAX_VL = 64;
   localparam int VLW = $clog2(MAX_VL + 1);
   localparam int CW = $clog2(MAX_VL);

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start_i = 1'b0;
   logic [1:0] mode_i = 2'd0;
   logic [1:0] ew_i = 2'd0;
   logic [AW-1:0] base_i = '0;
   logic [AW-1:0] stride_i = '0;
   logic [VLW-1:0] vlen_i = '0;
   logic [CW-1:0] idx_sel_o;
   logic [IDXW-1:0] idx_data_i;
   logic addr_valid_o;
   logic addr_ready_i = 1'b0;
   logic [AW-1:0] addr_o;
   logic done_o;
   logic busy_o;

   logic [IDXW-1:0] idx_tab [0:MAX_VL-1];
   assign idx_data_i = idx_tab[idx_sel_o];

   always #4 clk = ~clk;

   vag_top u_dut (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .mode_i(mode_i), .ew_i(ew_i),
      .base_i(base_i), .stride_i(stride_i), .vlen_i(vlen_i), .idx_sel_o(idx_sel_o),
      .idx_data_i(idx_data_i), .addr_valid_o(addr_valid_o), .addr_ready_i(addr_ready_i),
      .addr_o(addr_o), .done_o(done_o), .busy_o(busy_o)
   );

   int n_chk = 0;
   int n_bad = 0;
   logic [AW-1:0] exp_q[$];
   int exp_el[$];
   string cur_req = "R1";
   int stall_mode = 0;
   logic [7:0] lf = 8'hA5;
   logic done_seen = 1'b0;
   logic prev_v = 1'b0, prev_r = 1'b0, prev_done = 1'b0;
   logic [AW-1:0] prev_a = '0;
   logic mon_on = 1'b0;
   int cyc = 0;

   task automatic check(input string req, input logic ok, input logic [AW-1:0] act,
                        input logic [AW-1:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // monitor: runs between clock edges
   always @(negedge clk) begin
      if (mon_on) begin
         lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
         addr_ready_i = (stall_mode == 0) ? 1'b1 : (lf[0] | lf[2]);
         if (prev_v && !prev_r)
            check("R8", addr_valid_o && addr_o == prev_a, addr_o, prev_a);
         if (addr_valid_o && addr_ready_i) begin
            if (exp_q.size() == 0) check("R4", 1'b0, addr_o, '0);
            else begin
               check(cur_req, addr_o == exp_q[0], addr_o, exp_q[0]);
               if (cur_req == "R3")
                  check("R3", 32'(idx_sel_o) == 32'(exp_el[0]), 32'(idx_sel_o), 32'(exp_el[0]));
               void'(exp_q.pop_front());
               void'(exp_el.pop_front());
            end
         end
         if (done_o) begin
            check("R4", exp_q.size() == 0, 32'(exp_q.size()), 0);
            check("R7", !addr_valid_o && !prev_done, {prev_done, addr_valid_o}, 0);
            done_seen = 1'b1;
         end
         prev_v = addr_valid_o;
         prev_r = addr_ready_i;
         prev_a = addr_o;
         prev_done = done_o;
      end
   end

   task automatic run_seq(input string req, input logic [1:0] md, input logic [1:0] ew,
                          input logic [AW-1:0] base, input logic [AW-1:0] stride,
                          input int vl, input int stalls, input bit poke);
      int n;
      n = (vl > MAX_VL) ? MAX_VL : vl;
      cur_req = req;
      stall_mode = stalls;
      for (int i = 0; i < n; i++) begin
         logic [AW-1:0] e;
         if (md == 2'd1) e = base + stride * 32'(i);
         else if (md == 2'd2) e = base + {16'h0, idx_tab[i]};
         else e = base + (32'(1) << ew) * 32'(i);
         exp_q.push_back(e);
         exp_el.push_back(i);
      end
      @(negedge clk);
      done_seen = 1'b0;
      mode_i = md; ew_i = ew; base_i = base; stride_i = stride;
      vlen_i = VLW'(vl); start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      if (vl == 0) begin
         check("R6", done_o && !addr_valid_o, {done_o, addr_valid_o}, 2'b10);
      end else begin
         check("R9", busy_o, busy_o, 1);
      end
      if (poke) begin
         repeat (3) @(negedge clk);
         check("R9", busy_o, busy_o, 1);
         base_i = 32'hDEAD0000; mode_i = 2'd1; stride_i = 32'h100; vlen_i = VLW'(3);
         start_i = 1'b1;
         @(negedge clk);
         start_i = 1'b0;
      end
      while (!done_seen) @(negedge clk);
      @(negedge clk);
      check("R9", !busy_o && !done_o, {busy_o, done_o}, 0);
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000) begin
         n_bad++;
         n_chk++;
         $display("FAIL watchdog actual=%0d expected<150000", cyc);
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      for (int i = 0; i < MAX_VL; i++) idx_tab[i] = IDXW'((i * 37 + 5) * 13);
      idx_tab[3] = 16'hFFFF;
      idx_tab[4] = 16'h0000;
      repeat (3) @(negedge clk);
      check("R10", !addr_valid_o && !done_o && !busy_o,
            {addr_valid_o, done_o, busy_o}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R10", !addr_valid_o && !done_o && !busy_o,
            {addr_valid_o, done_o, busy_o}, 0);
      mon_on = 1'b1;

      run_seq("R1", 2'd0, 2'd3, 32'h0000_1000, 0, 8, 0, 0);
      run_seq("R1", 2'd0, 2'd0, 32'h0000_2001, 0, 5, 1, 0);
      run_seq("R1", 2'd3, 2'd1, 32'h0000_3000, 0, 7, 1, 0);
      run_seq("R1", 2'd0, 2'd2, 32'hFFFF_FFF8, 0, 6, 1, 0);
      run_seq("R2", 2'd1, 2'd3, 32'h0000_4000, 32'd24, 10, 1, 0);
      run_seq("R2", 2'd1, 2'd2, 32'h0000_0020, 32'hFFFF_FFF0, 6, 0, 0);
      run_seq("R2", 2'd1, 2'd0, 32'hFFFF_FFF0, 32'd8, 4, 1, 0);
      run_seq("R3", 2'd2, 2'd3, 32'h0001_0000, 0, 12, 1, 0);
      run_seq("R3", 2'd2, 2'd0, 32'hFFFF_FF00, 0, 9, 0, 0);
      run_seq("R6", 2'd0, 2'd3, 32'h0000_5000, 0, 0, 0, 0);
      run_seq("R5", 2'd0, 2'd0, 32'h0000_6000, 0, 100, 1, 0);
      run_seq("R5", 2'd2, 2'd0, 32'h0000_7000, 0, 64, 1, 0);
      run_seq("R9", 2'd0, 2'd3, 32'h0000_8000, 0, 20, 1, 1);
      run_seq("R4", 2'd1, 2'd3, 32'h0000_9000, 32'd3, 1, 1, 0);

      mon_on = 1'b0;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

endmodule